// File: doc/BRIEF.md
# Line Topology Link Delay Calculator

This block works out, for every node of a daisy-chained network, how far that node lies from the first node in time. Each node reports four timestamps taken against its own free-running nanosecond clock. Two are taken as a frame passes on its way out: arrival at the inbound port and departure from the outbound port. Two are taken as the frame comes back: arrival at the outbound port and departure from the inbound port. The timestamp sets are fed in chain order, first node first, over a valid/ready input. For each node the block produces two cumulative figures. One is the cable delay summed over all links from the first node. The other is the forward residence time summed over all upstream nodes.

The unknown clock offset between two neighbours is cancelled by taking the difference of two round-trip spans, each measured by one node in its own timebase. Cables are treated as symmetric, so half of that difference is the one-way link delay. Only outbound-direction residence is accumulated; residence on the return path is never added. The last node of a chain also yields its turnaround time, which is its return departure minus its forward arrival. That value is held on an output, and a done flag marks the end of the chain. All arithmetic wraps modulo 2^32, so counter rollover between timestamps is harmless.

Top module: `ldc_top`

## Requirements
- R1: While `rst` is high, `in_ready`, `out_valid` and `chain_done` are 0, and after reset `tail_turn` reads 0.
- R2: The first node of a chain (`out_idx` = 0) reports `out_cable` = 0 and `out_station` = 0.
- R3: The link delay from node j to the next node k is ((j.ret_rx_p1 − j.fwd_tx_p1) − (k.ret_tx_p0 − k.fwd_rx_p0)) taken modulo 2^32 and then arithmetically shifted right by one as a signed 32-bit value, so an odd negative difference rounds toward minus infinity.
- R4: `out_cable` of node k is `out_cable` of node k−1 plus the R3 link delay between them, modulo 2^32.
- R5: `out_station` of node k is `out_station` of node k−1 plus (fwd_tx_p1 − fwd_rx_p0) of node k−1. Neither the node's own residence nor any return-direction residence is included.
- R6: Every subtraction and sum wraps modulo 2^32, so timestamps that roll over past 0xFFFFFFFF give the same results as unwrapped values.
- R7: When the final node of a chain is accepted, `tail_turn` becomes its (ret_tx_p0 − fwd_rx_p0). It keeps that value until the final node of a later chain is accepted.
- R8: `chain_done` is 1 exactly in the output cycle of a chain's final node. The node accepted next starts a new chain at `out_idx` = 0, even in the immediately following cycle. Inside a chain, `out_idx` rises by one per node.
- R9: A chain is capped at MAX_NODES (16) nodes. The node at index 15 is treated as final even when `in_last` is 0.
- R10: `in_ready` is 1 in every cycle after reset. A node accepted at a clock edge has its result on the outputs, with `out_valid` = 1, for the one cycle after that edge. Cycles without `in_valid` produce `out_valid` = 0 and leave the accumulated state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A timestamp set is presented |
| in_ready | output | 1 | Block accepts a timestamp set this cycle |
| in_fwd_rx_p0 | input | 32 | Outbound frame arrival at inbound port |
| in_fwd_tx_p1 | input | 32 | Outbound frame departure from outbound port |
| in_ret_rx_p1 | input | 32 | Returning frame arrival at outbound port |
| in_ret_tx_p0 | input | 32 | Returning frame departure from inbound port |
| in_last | input | 1 | This node ends the chain |
| out_valid | output | 1 | Result for one node is present |
| out_idx | output | 4 | Position of the node in its chain, 0 = first |
| out_cable | output | 32 | Cumulative cable delay from the first node |
| out_station | output | 32 | Cumulative upstream forward residence |
| chain_done | output | 1 | The present result belongs to the chain's final node |
| tail_turn | output | 32 | Turnaround time of the most recent final node |

## Verification
The close of one chain and the start of the next can fall on adjacent edges. The final node's result, with `chain_done` and the new `tail_turn`, sits on the outputs in the same cycle in which the first node of the next chain is accepted. The bench provokes this by sending chains back to back with no idle cycle, and by running a 16-node chain without a last flag straight into a new node. The scoreboard then requires index 0 with zero sums for that new node, the old chain's `tail_turn` until the new final node, and no carry-over of cable or station sums across the boundary.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    parameter int LDC_TS_W = 32;

    typedef logic [LDC_TS_W-1:0] ts_t;

    // Full set of stamps supplied for one node.
    typedef struct packed {
        ts_t fwd_rx_p0;
        ts_t fwd_tx_p1;
        ts_t ret_rx_p1;
        ts_t ret_tx_p0;
    } node_stamps_t;

    // Subset that must be remembered from the upstream neighbour.
    typedef struct packed {
        ts_t fwd_rx_p0;
        ts_t fwd_tx_p1;
        ts_t ret_rx_p1;
    } up_stamps_t;

    // Modulo subtraction; rollover of the node clock cancels out.
    function automatic ts_t ts_sub(input ts_t a, input ts_t b);
        return a - b;
    endfunction

    // Halved difference of two round trips, arithmetic shift.
    function automatic ts_t half_gap(input ts_t span_up, input ts_t span_dn);
        ts_t gap;
        gap = span_up - span_dn;
        return ts_t'($signed(gap) >>> 1);
    endfunction

endpackage

// File: rtl/ldc_link_calc.sv
module ldc_link_calc
    import ldc_pkg::*;
(
    input  up_stamps_t up,
    input  ts_t        cur_fwd_rx_p0,
    input  ts_t        cur_ret_tx_p0,
    output ts_t        link_dly,
    output ts_t        up_residence,
    output ts_t        cur_turn
);

    ts_t span_up;
    ts_t span_dn;

    always_comb begin
        // Round trip seen by the upstream node on its outbound port.
        span_up      = ts_sub(up.ret_rx_p1, up.fwd_tx_p1);
        // Time the frame spent beyond the upstream cable, per current node.
        span_dn      = ts_sub(cur_ret_tx_p0, cur_fwd_rx_p0);
        link_dly     = half_gap(span_up, span_dn);
        up_residence = ts_sub(up.fwd_tx_p1, up.fwd_rx_p0);
        cur_turn     = span_dn;
    end

endmodule

// File: rtl/ldc_chain_acc.sv
module ldc_chain_acc
    import ldc_pkg::*;
#(
    parameter int MAX_NODES = 16,
    localparam int IDX_W = (MAX_NODES > 1) ? $clog2(MAX_NODES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  node_stamps_t     cur,
    input  logic             cur_last,
    output logic             res_valid,
    output logic [IDX_W-1:0] res_idx,
    output ts_t              res_cable,
    output ts_t              res_station,
    output logic             res_end,
    output ts_t              res_turn
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_NODES - 1);

    up_stamps_t       up_q;
    logic             have_up_q;
    ts_t              cable_q;
    ts_t              station_q;
    logic [IDX_W-1:0] idx_q;
    logic             end_q;
    ts_t              turn_q;
    logic             valid_q;

    ts_t              link_dly;
    ts_t              up_res;
    ts_t              cur_turn;

    logic [IDX_W-1:0] nxt_idx;
    ts_t              nxt_cable;
    ts_t              nxt_station;
    logic             nxt_end;

    ldc_link_calc u_link (
        .up            (up_q),
        .cur_fwd_rx_p0 (cur.fwd_rx_p0),
        .cur_ret_tx_p0 (cur.ret_tx_p0),
        .link_dly      (link_dly),
        .up_residence  (up_res),
        .cur_turn      (cur_turn)
    );

    always_comb begin
        if (have_up_q) begin
            nxt_idx     = idx_q + 1'b1;
            nxt_cable   = cable_q + link_dly;
            nxt_station = station_q + up_res;
        end else begin
            nxt_idx     = '0;
            nxt_cable   = '0;
            nxt_station = '0;
        end
        nxt_end = cur_last || (nxt_idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q      <= '0;
            have_up_q <= 1'b0;
            cable_q   <= '0;
            station_q <= '0;
            idx_q     <= '0;
            end_q     <= 1'b0;
            turn_q    <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= fire;
            if (fire) begin
                up_q.fwd_rx_p0 <= cur.fwd_rx_p0;
                up_q.fwd_tx_p1 <= cur.fwd_tx_p1;
                up_q.ret_rx_p1 <= cur.ret_rx_p1;
                have_up_q      <= !nxt_end;
                cable_q        <= nxt_cable;
                station_q      <= nxt_station;
                idx_q          <= nxt_idx;
                end_q          <= nxt_end;
                if (nxt_end) begin
                    turn_q <= cur_turn;
                end
            end
        end
    end

    assign res_valid   = valid_q;
    assign res_idx     = idx_q;
    assign res_cable   = cable_q;
    assign res_station = station_q;
    assign res_end     = end_q;
    assign res_turn    = turn_q;

    // R2: a chain's head carries no accumulated delay
    p_head_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_idx == '0) |-> (res_cable == '0 && res_station == '0));

    // R8: inside a chain the index steps by one
    p_idx_step_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && res_valid && !res_end) |=> (res_idx == $past(res_idx) + 1'b1));

    // R8: after a final node the next node restarts at zero
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && res_valid && res_end) |=> (res_idx == '0 && res_cable == '0));

    // R9: the highest index always closes the chain
    p_cap_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_idx == LAST_IDX) |-> res_end);

    // R7: turnaround only changes together with a chain end
    p_tail_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && res_end) |-> $stable(res_turn));

endmodule

// File: rtl/ldc_top.sv
module ldc_top
    import ldc_pkg::*;
#(
    parameter int MAX_NODES = 16,
    localparam int IDX_W = (MAX_NODES > 1) ? $clog2(MAX_NODES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_fwd_rx_p0,
    input  logic [31:0]      in_fwd_tx_p1,
    input  logic [31:0]      in_ret_rx_p1,
    input  logic [31:0]      in_ret_tx_p0,
    input  logic             in_last,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic [31:0]      out_cable,
    output logic [31:0]      out_station,
    output logic             chain_done,
    output logic [31:0]      tail_turn
);

    node_stamps_t cur;
    logic         fire;
    logic         res_end;

    assign in_ready = !rst;
    assign fire     = in_valid && in_ready;

    always_comb begin
        cur.fwd_rx_p0 = in_fwd_rx_p0;
        cur.fwd_tx_p1 = in_fwd_tx_p1;
        cur.ret_rx_p1 = in_ret_rx_p1;
        cur.ret_tx_p0 = in_ret_tx_p0;
    end

    ldc_chain_acc #(
        .MAX_NODES (MAX_NODES)
    ) u_acc (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .cur         (cur),
        .cur_last    (in_last),
        .res_valid   (out_valid),
        .res_idx     (out_idx),
        .res_cable   (out_cable),
        .res_station (out_station),
        .res_end     (res_end),
        .res_turn    (tail_turn)
    );

    assign chain_done = out_valid && res_end;

    // R10: no result without an accepted node one edge earlier
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !out_valid);

    // R10: an accepted node always yields a result next cycle
    p_fire_result_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

endmodule

// File: tb/sim_ldc_top.sv
module sim_ldc_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_fwd_rx_p0 = '0;
    logic [31:0] in_fwd_tx_p1 = '0;
    logic [31:0] in_ret_rx_p1 = '0;
    logic [31:0] in_ret_tx_p0 = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [3:0]  out_idx;
    logic [31:0] out_cable;
    logic [31:0] out_station;
    logic        chain_done;
    logic [31:0] tail_turn;

    always #5 clk = ~clk;

    ldc_top u0 (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_fwd_rx_p0 (in_fwd_rx_p0),
        .in_fwd_tx_p1 (in_fwd_tx_p1),
        .in_ret_rx_p1 (in_ret_rx_p1),
        .in_ret_tx_p0 (in_ret_tx_p0),
        .in_last      (in_last),
        .out_valid    (out_valid),
        .out_idx      (out_idx),
        .out_cable    (out_cable),
        .out_station  (out_station),
        .chain_done   (chain_done),
        .tail_turn    (tail_turn)
    );

    typedef struct {
        int unsigned idx;
        logic [31:0] cable;
        logic [31:0] station;
        bit          last;
        logic [31:0] turn;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model state, built from the requirements
    bit          m_have = 0;
    int unsigned m_idx = 0;
    logic [31:0] m_rx0, m_tx1, m_rx1, m_cable, m_station;
    logic [31:0] exp_tail = '0;

    task automatic check(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [31:0] d, input bit lst);
        exp_t e;
        logic [31:0] gap;
        if (!m_have) begin
            e.idx = 0; e.cable = '0; e.station = '0;
        end else begin
            e.idx     = m_idx + 1;
            gap       = (m_rx1 - m_tx1) - (d - a);
            e.cable   = m_cable + 32'($signed(gap) >>> 1);
            e.station = m_station + (m_tx1 - m_rx0);
        end
        e.last = lst || (e.idx == 15);
        e.turn = d - a;
        m_have = !e.last; m_idx = e.idx;
        m_rx0 = a; m_tx1 = b; m_rx1 = c;
        m_cable = e.cable; m_station = e.station;
        @(negedge clk);
        q.push_back(e);
        in_valid = 1'b1;
        in_fwd_rx_p0 = a; in_fwd_tx_p1 = b; in_ret_rx_p1 = c; in_ret_tx_p0 = d;
        in_last = lst;
        check(in_ready == 1'b1, "R10 in_ready high after reset", 32'(in_ready), 32'd1);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard when a result appears
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10 result without accepted node", 32'(out_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(32'(out_idx) == e.idx, "R8 R9 node index", 32'(out_idx), e.idx);
                    check(out_cable == e.cable, "R2 R3 R4 R6 cumulative cable", out_cable, e.cable);
                    check(out_station == e.station, "R2 R5 R6 cumulative station", out_station, e.station);
                    check(chain_done == e.last, "R8 R9 chain_done", 32'(chain_done), 32'(e.last));
                    if (e.last) exp_tail = e.turn;
                    check(tail_turn == exp_tail, "R7 tail_turn", tail_turn, exp_tail);
                end
            end else begin
                if (chain_done) check(1'b0, "R8 done without result", 32'(chain_done), 32'd0);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b0, "R1 in_ready in reset", 32'(in_ready), 32'd0);
        check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
        check(chain_done == 1'b0, "R1 chain_done in reset", 32'(chain_done), 32'd0);
        check(tail_turn == 32'd0, "R1 tail_turn in reset", tail_turn, 32'd0);
        rst = 1'b0;

        // Three-node chain, distinct timebases per node (R2 R3 R4 R5)
        send(32'd100,   32'd150,   32'd900,   32'd960,   1'b0);
        send(32'd5000,  32'd5040,  32'd5600,  32'd5660,  1'b0);
        send(32'd70000, 32'd70030, 32'd70031, 32'd70100, 1'b1);
        idle(3);
        // R7: turnaround held through idle cycles
        check(tail_turn == 32'd100, "R7 tail held after chain", tail_turn, 32'd100);

        // Odd negative gap: arithmetic shift floors (R3)
        send(32'd10, 32'd20, 32'd30, 32'd40, 1'b0);
        send(32'd0,  32'd5,  32'd6,  32'd25, 1'b1);
        // Back to back: single-node chain right after a final node (R8)
        send(32'd400, 32'd410, 32'd420, 32'd777, 1'b1);
        // Another chain with a gap in the middle (R10)
        send(32'hFFFF_FF00, 32'hFFFF_FF80, 32'h0000_0100, 32'h0000_0180, 1'b0);
        idle(4);
        check(out_valid == 1'b0, "R10 no output while idle", 32'(out_valid), 32'd0);
        // Wrapping stamps in the next node (R6)
        send(32'hFFFF_FFF0, 32'h0000_0010, 32'h0000_0020, 32'h0000_0090, 1'b0);
        send(32'h7FFF_FFF0, 32'h8000_0008, 32'h8000_0009, 32'h8000_0030, 1'b1);
        idle(2);

        // 16 nodes with no last flag: cap forces an end (R9), then restart (R8)
        for (int n = 0; n < 16; n++) begin
            send(32'(n * 1000 + 7), 32'(n * 1000 + 47 + n), 32'(n * 1000 + 900 - 3 * n),
                 32'(n * 1000 + 960 - 2 * n), 1'b0);
        end
        send(32'd55, 32'd60, 32'd65, 32'd99, 1'b0);
        send(32'd1000, 32'd1030, 32'd1040, 32'd1070, 1'b1);
        idle(3);
        check(tail_turn == 32'd70, "R7 tail after capped run", tail_turn, 32'd70);
        check(q.size() == 0, "R10 all results delivered", 32'(q.size()), 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule